// File: doc/BRIEF.md
# Gear Shifter and Wheel Input Conditioner

This block sits between the raw driver controls and a host processor's read path. Four momentary gear-position switches arrive active low inside a 16-bit input port. Each time the host reads the port, the block looks for switches that have just gone low since the previous read. It keeps a one-hot gear state: picking a new gear replaces the state, and picking the gear already held returns it to neutral. The port word handed back to the host shows the held gear as a low bit in the gear field.

The block also tracks an 8-bit steering wheel sample, scaled up to 12 bits. On every wheel read it sorts the scaled value into coarse zones of a fixed width. If the zone differs from the zone of the previous wheel read, a sticky edge flag is set. The flag appears as an inverted bit in the port word and stays set until the host pulses a clear strobe. A wheel read returns the scaled value's low byte in the upper half of a 16-bit word, with all ones below it.

Top module: `gear_wheel_conditioner`

## Requirements
- R1: After reset, port_word and wheel_word are 0. The gear state, the edge flag, the stored previous port sample and the stored previous wheel value are also 0.
- R2: On a cycle with port_rd high, gear g (port bit GEAR_LSB+g, g = 0..3, with GEAR_LSB = 8) is selected only when that bit of port_in is 0 and was 1 in the port_in value captured at the previous port read. Because the captured value starts at 0, a switch already low at the first read after reset is not selected.
- R3: The gear state is one-hot with codes 1, 2, 4 and 8 for gears 0 to 3, or 0 for neutral. Selecting the gear whose code is already held gives 0. Selecting any other gear replaces the state with that gear's code.
- R4: When several gears are selected in one read, they are applied one after another from gear 0 up to gear 3, each against the state the previous one left. The last selected gear decides the result.
- R5: One cycle after a port read, port_word equals that read's port_in with bits 8 to 11 forced to 1 and then XORed with the updated gear state placed at bit 8, so the held gear reads 0. All other bits pass through, except bit 14 (see R6).
- R6: Bit 14 of the returned port word is inverted when the edge flag was set before the read's clock edge.
- R7: One cycle after a wheel read, wheel_word[15:8] equals the low 8 bits of (wheel_in << 4), that is {wheel_in[3:0], 4'b0000}, and wheel_word[7:0] equals 8'hFF.
- R8: On a wheel read, the edge flag sets when floor(scaled/240) differs from floor(previous scaled/240), where scaled is wheel_in << 4 as a 12-bit value. The read then stores scaled as the new previous value. Once set, the flag stays set until it is cleared.
- R9: A pulse on edge_clr clears the edge flag. If the same cycle also holds a wheel read that sets the flag, the flag ends up set.
- R10: Without port_rd, port_word and the gear state hold. Without wheel_rd, wheel_word and the previous wheel value hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_in | input | 16 | Raw control port; bits 8 to 11 are active-low gear switches |
| port_rd | input | 1 | Port read strobe, one cycle |
| wheel_in | input | 8 | Raw steering wheel sample |
| wheel_rd | input | 1 | Wheel read strobe, one cycle |
| edge_clr | input | 1 | Clears the wheel edge flag |
| port_word | output | 16 | Conditioned port word from the last port read |
| wheel_word | output | 16 | Wheel word from the last wheel read |

## Verification
The bench builds the block with its default parameters: four gears from bit 8, the edge flag at bit 14, an 8-bit wheel shifted by 4 and a zone width of 240. With these values the zone boundaries fall between wheel samples 14 and 15, 29 and 30, and so on. The directed wheel steps therefore land exactly on and beside each boundary, and the top sample 255 reaches zone 17. The 16-bit port lets the gear chain see every combination of several switches falling in the same read. A long pseudo-random stretch mixes simultaneous port reads, wheel reads and clears against the behavioural model.

// File: rtl/gwc_pkg.sv
`timescale 1ns/1ps
package gwc_pkg;

    localparam int unsigned DEF_PORT_W      = 16;
    localparam int unsigned DEF_GEARS       = 4;
    localparam int unsigned DEF_GEAR_LSB    = 8;
    localparam int unsigned DEF_EDGE_BIT    = 14;
    localparam int unsigned DEF_WHEEL_IN_W  = 8;
    localparam int unsigned DEF_WHEEL_SHIFT = 4;
    localparam int unsigned DEF_ZONE_DIV    = 240;

    // action taken by one stage of the gear selection chain
    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_TAKE = 2'd1,
        ACT_DROP = 2'd2
    } gear_act_e;

    // coarse zone of a scaled wheel value
    function automatic logic [31:0] zone_index(input logic [31:0] value,
                                               input int unsigned div);
        return value / div;
    endfunction

    // decide what one falling switch does to the running state
    function automatic gear_act_e gear_decide(input logic fell,
                                              input logic match);
        if (!fell)
            return ACT_KEEP;
        else if (match)
            return ACT_DROP;
        else
            return ACT_TAKE;
    endfunction

endpackage

// File: rtl/gwc_gear_latch.sv
`timescale 1ns/1ps
module gwc_gear_latch
    import gwc_pkg::*;
#(
    parameter int unsigned GEARS = DEF_GEARS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [GEARS-1:0] raw_gears,
    output logic [GEARS-1:0] state_q,
    output logic [GEARS-1:0] state_next
);

    logic [GEARS-1:0] prev_q;
    logic [GEARS-1:0] fell;

    // changed since last read and now low means high before, low now
    assign fell = prev_q & ~raw_gears;

    // ordered chain: gear 0 first, the highest gear last
    always_comb begin
        logic [GEARS-1:0] run;
        logic [GEARS-1:0] code;
        gear_act_e        act;
        run = state_q;
        for (int g = 0; g < GEARS; g++) begin
            code    = '0;
            code[g] = 1'b1;
            act     = gear_decide(fell[g], run == code);
            case (act)
                ACT_TAKE: run = code;
                ACT_DROP: run = '0;
                default:  run = run;
            endcase
        end
        state_next = run;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            prev_q  <= '0;
        end else if (rd_en) begin
            state_q <= state_next;
            prev_q  <= raw_gears;
        end
    end

endmodule

// File: rtl/gwc_port_composer.sv
`timescale 1ns/1ps
module gwc_port_composer
    import gwc_pkg::*;
#(
    parameter int unsigned PORT_W   = DEF_PORT_W,
    parameter int unsigned GEARS    = DEF_GEARS,
    parameter int unsigned GEAR_LSB = DEF_GEAR_LSB,
    parameter int unsigned EDGE_BIT = DEF_EDGE_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] raw_port,
    input  logic [GEARS-1:0]  gear_state,
    input  logic              edge_flag,
    output logic [PORT_W-1:0] port_q
);

    localparam logic [PORT_W-1:0] GEAR_MASK =
        PORT_W'(((64'd1 << GEARS) - 64'd1) << GEAR_LSB);
    localparam logic [PORT_W-1:0] EDGE_MASK = PORT_W'(64'd1 << EDGE_BIT);

    logic [PORT_W-1:0] forced;
    logic [PORT_W-1:0] geared;
    logic [PORT_W-1:0] word_d;

    assign forced = raw_port | GEAR_MASK;
    assign geared = forced ^ (PORT_W'(gear_state) << GEAR_LSB);
    assign word_d = edge_flag ? (geared ^ EDGE_MASK) : geared;

    always_ff @(posedge clk) begin
        if (rst)
            port_q <= '0;
        else if (rd_en)
            port_q <= word_d;
    end

endmodule

// File: rtl/gwc_wheel_tracker.sv
`timescale 1ns/1ps
module gwc_wheel_tracker
    import gwc_pkg::*;
#(
    parameter int unsigned IN_W     = DEF_WHEEL_IN_W,
    parameter int unsigned SHIFT    = DEF_WHEEL_SHIFT,
    parameter int unsigned ZONE_DIV = DEF_ZONE_DIV,
    parameter int unsigned OUT_W    = DEF_PORT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic             clr,
    input  logic [IN_W-1:0]  raw_wheel,
    output logic             edge_q,
    output logic [OUT_W-1:0] word_q
);

    localparam int unsigned SC_W = IN_W + SHIFT;
    localparam int unsigned HALF = OUT_W / 2;

    logic [SC_W-1:0]  scaled;
    logic [SC_W-1:0]  prev_q;
    logic             crossed;
    logic [OUT_W-1:0] word_d;

    assign scaled  = {raw_wheel, {SHIFT{1'b0}}};
    assign crossed = rd_en &&
                     (zone_index(32'(scaled), ZONE_DIV) !=
                      zone_index(32'(prev_q), ZONE_DIV));
    assign word_d  = (OUT_W'(scaled) << HALF) | OUT_W'({HALF{1'b1}});

    // set beats clear when both arrive together
    always_ff @(posedge clk) begin
        if (rst)
            edge_q <= 1'b0;
        else if (crossed)
            edge_q <= 1'b1;
        else if (clr)
            edge_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            word_q <= '0;
        end else if (rd_en) begin
            prev_q <= scaled;
            word_q <= word_d;
        end
    end

endmodule

// File: rtl/gear_wheel_conditioner.sv
`timescale 1ns/1ps
module gear_wheel_conditioner
    import gwc_pkg::*;
#(
    parameter int unsigned PORT_W      = DEF_PORT_W,
    parameter int unsigned GEARS       = DEF_GEARS,
    parameter int unsigned GEAR_LSB    = DEF_GEAR_LSB,
    parameter int unsigned EDGE_BIT    = DEF_EDGE_BIT,
    parameter int unsigned WHEEL_IN_W  = DEF_WHEEL_IN_W,
    parameter int unsigned WHEEL_SHIFT = DEF_WHEEL_SHIFT,
    parameter int unsigned ZONE_DIV    = DEF_ZONE_DIV
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PORT_W-1:0]     port_in,
    input  logic                  port_rd,
    input  logic [WHEEL_IN_W-1:0] wheel_in,
    input  logic                  wheel_rd,
    input  logic                  edge_clr,
    output logic [PORT_W-1:0]     port_word,
    output logic [PORT_W-1:0]     wheel_word
);

    logic [GEARS-1:0] gear_state_q;
    logic [GEARS-1:0] gear_state_d;
    logic             edge_q;

    gwc_gear_latch #(
        .GEARS(GEARS)
    ) gear_i (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (port_rd),
        .raw_gears (port_in[GEAR_LSB +: GEARS]),
        .state_q   (gear_state_q),
        .state_next(gear_state_d)
    );

    gwc_port_composer #(
        .PORT_W  (PORT_W),
        .GEARS   (GEARS),
        .GEAR_LSB(GEAR_LSB),
        .EDGE_BIT(EDGE_BIT)
    ) port_i (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (port_rd),
        .raw_port  (port_in),
        .gear_state(gear_state_d),
        .edge_flag (edge_q),
        .port_q    (port_word)
    );

    gwc_wheel_tracker #(
        .IN_W    (WHEEL_IN_W),
        .SHIFT   (WHEEL_SHIFT),
        .ZONE_DIV(ZONE_DIV),
        .OUT_W   (PORT_W)
    ) wheel_i (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (wheel_rd),
        .clr      (edge_clr),
        .raw_wheel(wheel_in),
        .edge_q   (edge_q),
        .word_q   (wheel_word)
    );

endmodule

// File: rtl/gwc_checker.sv
`timescale 1ns/1ps
module gwc_checker #(
    parameter int unsigned PORT_W   = 16,
    parameter int unsigned GEARS    = 4,
    parameter int unsigned GEAR_LSB = 8,
    parameter int unsigned EDGE_BIT = 14
) (
    input logic                clk,
    input logic                rst,
    input logic                port_rd,
    input logic                wheel_rd,
    input logic                edge_clr,
    input logic                edge_in,
    input logic [PORT_W-1:0]   port_word,
    input logic [PORT_W/2-1:0] wheel_low,
    input logic [GEARS-1:0]    gear_state,
    input logic                edge_flag
);

    // R3
    gear_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gear_state));

    // R5
    gear_field_chk: assert property (@(posedge clk) disable iff (rst)
        port_rd |=> (port_word[GEAR_LSB +: GEARS] == ~gear_state));

    // R6
    edge_bit_chk: assert property (@(posedge clk) disable iff (rst)
        port_rd |=> (port_word[EDGE_BIT] == ($past(edge_in) ^ $past(edge_flag))));

    // R7
    wheel_low_chk: assert property (@(posedge clk) disable iff (rst)
        wheel_rd |=> (wheel_low == '1));

    // R8
    edge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_flag && !edge_clr) |=> edge_flag);

    // R9
    edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_clr && !wheel_rd) |=> !edge_flag);

    // R10
    port_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !port_rd |=> ($stable(port_word) && $stable(gear_state)));

endmodule

bind gear_wheel_conditioner gwc_checker #(
    .PORT_W  (PORT_W),
    .GEARS   (GEARS),
    .GEAR_LSB(GEAR_LSB),
    .EDGE_BIT(EDGE_BIT)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .port_rd   (port_rd),
    .wheel_rd  (wheel_rd),
    .edge_clr  (edge_clr),
    .edge_in   (port_in[EDGE_BIT]),
    .port_word (port_word),
    .wheel_low (wheel_word[PORT_W/2-1:0]),
    .gear_state(gear_state_q),
    .edge_flag (edge_q)
);

// File: tb/gear_wheel_conditioner_tb.sv
`timescale 1ns/1ps
module gear_wheel_conditioner_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] port_in = 16'hFFFF;
    logic        port_rd = 1'b0;
    logic [7:0]  wheel_in = 8'h00;
    logic        wheel_rd = 1'b0;
    logic        edge_clr = 1'b0;
    logic [15:0] port_word;
    logic [15:0] wheel_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    int m_state, m_edge, m_prev_port, m_prev_wheel, m_port_out, m_wheel_out;
    int unsigned seed = 32'h1234_5678;

    always #10 clk = ~clk;

    gear_wheel_conditioner dut_i (
        .clk       (clk),
        .rst       (rst),
        .port_in   (port_in),
        .port_rd   (port_rd),
        .wheel_in  (wheel_in),
        .wheel_rd  (wheel_rd),
        .edge_clr  (edge_clr),
        .port_word (port_word),
        .wheel_word(wheel_word)
    );

    task automatic model_reset();
        m_state = 0; m_edge = 0; m_prev_port = 0; m_prev_wheel = 0;
        m_port_out = 0; m_wheel_out = 0;
    endtask

    task automatic model_step(input int p, input bit prd, input int w,
                              input bit wrd, input bit clr);
        int st, res, nw, ne;
        if (prd) begin
            st = m_state;
            for (int i = 0; i < 4; i++) begin
                if ((((m_prev_port >> (8 + i)) & 1) == 1) &&
                    (((p >> (8 + i)) & 1) == 0))
                    st = (st == (1 << i)) ? 0 : (1 << i);
            end
            res = (p | 32'h0F00) ^ (st << 8);
            if (m_edge != 0) res = res ^ 32'h4000;
            m_port_out  = res & 32'hFFFF;
            m_prev_port = p;
            m_state     = st;
        end
        ne = m_edge;
        if (clr) ne = 0;
        if (wrd) begin
            nw = (w << 4) & 32'hFFF;
            if ((m_prev_wheel / 240) != (nw / 240)) ne = 1;
            m_prev_wheel = nw;
            m_wheel_out  = ((nw << 8) | 32'hFF) & 32'hFFFF;
        end
        m_edge = ne;
    endtask

    task automatic compare(input string tag);
        n_cmp++;
        if (port_word !== 16'(m_port_out)) begin
            n_bad++;
            $display("FAIL %s port_word actual=%04h expected=%04h", tag, port_word, 16'(m_port_out));
        end
        n_cmp++;
        if (wheel_word !== 16'(m_wheel_out)) begin
            n_bad++;
            $display("FAIL %s wheel_word actual=%04h expected=%04h", tag, wheel_word, 16'(m_wheel_out));
        end
    endtask

    task automatic step(input logic [15:0] p, input bit prd, input logic [7:0] w,
                        input bit wrd, input bit clr, input string tag);
        port_in = p; port_rd = prd; wheel_in = w; wheel_rd = wrd; edge_clr = clr;
        model_step(int'(p), prd, int'(w), wrd, clr);
        @(posedge clk);
        @(negedge clk);
        port_rd = 1'b0; wheel_rd = 1'b0; edge_clr = 1'b0;
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; port_rd = 1'b0; wheel_rd = 1'b0; edge_clr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        compare("R1 reset");
    endtask

    function automatic int unsigned next_rand(input int unsigned s);
        int unsigned x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        do_reset();
        // R1: first read sees no edge flag and no gear
        step(16'hFFFF, 1, 8'h00, 0, 0, "R1 first read");
        do_reset();
        // R2: switch already low at first read is not selected
        step(16'hFEFF, 1, 8'h00, 0, 0, "R2 low at first read");
        step(16'hFEFF, 1, 8'h00, 0, 0, "R2 held low");
        step(16'hFFFF, 1, 8'h00, 0, 0, "R2 release");
        step(16'hFEFF, 1, 8'h00, 0, 0, "R2 fresh press");
        // R3: reselect same gear -> neutral; other gear replaces
        step(16'hFFFF, 1, 8'h00, 0, 0, "R3 release");
        step(16'hFEFF, 1, 8'h00, 0, 0, "R3 same gear neutral");
        step(16'hFFFF, 1, 8'h00, 0, 0, "R3 release2");
        step(16'hFBFF, 1, 8'h00, 0, 0, "R3 other gear");
        step(16'hFFFF, 1, 8'h00, 0, 0, "R3 release3");
        step(16'hF7FF, 1, 8'h00, 0, 0, "R3 top gear");
        // R10: idle, and switch activity without a read
        step(16'hF0FF, 0, 8'h00, 0, 0, "R10 no read");
        step(16'hFFFF, 0, 8'h00, 0, 0, "R10 idle");
        // R4: several gears fall in one read
        step(16'hFFFF, 1, 8'h00, 0, 0, "R4 prep");
        step(16'hF0FF, 1, 8'h00, 0, 0, "R4 all four");
        step(16'hFFFF, 1, 8'h00, 0, 0, "R4 release");
        step(16'hFAFF, 1, 8'h00, 0, 0, "R4 two gears");
        // R5: other bits pass through
        step(16'h0A5A, 1, 8'h00, 0, 0, "R5 passthrough");
        step(16'h3F00, 1, 8'h00, 0, 0, "R5 passthrough2");
        // R7, R8: zone boundaries with the default divisor
        step(16'hFFFF, 0, 8'd14, 1, 0, "R8 same zone 224");
        step(16'hFFFF, 1, 8'd14, 0, 0, "R6 flag still clear");
        step(16'hFFFF, 0, 8'd15, 1, 0, "R8 cross to 240");
        step(16'hFFFF, 1, 8'd15, 0, 0, "R6 flag inverts bit14");
        step(16'hBFFF, 1, 8'd15, 0, 0, "R6 bit14 low in");
        step(16'hFFFF, 0, 8'd29, 1, 0, "R8 sticky, same zone");
        step(16'hFFFF, 0, 8'd0, 0, 1, "R9 clear");
        step(16'hFFFF, 1, 8'd0, 0, 0, "R9 bit14 after clear");
        step(16'hFFFF, 0, 8'd29, 1, 0, "R8 no cross 464");
        step(16'hFFFF, 1, 8'd0, 0, 0, "R8 still clear");
        step(16'hFFFF, 0, 8'd30, 1, 0, "R8 cross 480");
        step(16'hFFFF, 0, 8'd14, 1, 1, "R9 set wins over clear");
        step(16'hFFFF, 1, 8'd0, 0, 0, "R9 flag kept");
        step(16'hFFFF, 0, 8'd0, 0, 1, "R9 clear again");
        step(16'hFFFF, 0, 8'd255, 1, 0, "R7 top value");
        step(16'hFFFF, 1, 8'd255, 1, 0, "R6 simultaneous reads");
        step(16'hFFFF, 0, 8'hA7, 0, 0, "R10 wheel hold");
        step(16'hFFFF, 0, 8'h5C, 1, 1, "R7 odd nibble");
        // mid-run reset
        do_reset();
        // mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] p;
            logic [7:0]  w;
            seed = next_rand(seed);
            p = 16'(seed);
            p[11:8] = p[11:8] | ~(4'(seed >> 16) & 4'(seed >> 20));
            w = 8'(seed >> 24);
            seed = next_rand(seed);
            step(p, seed[0], w, seed[1] & seed[2], seed[3] & seed[4], "R4 R8 R9 random");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule